// File: doc/BRIEF.md
# Guarded Clock Divider Control

This block keeps the divide setting for a system clock. It produces a clock-enable pulse from the master clock, one cycle wide, once every N master cycles. N is a power of two from 1 to 256. A processor reads and writes one 8-bit control register through a simple write strobe and a read bus.

A single write cannot change the divide setting. Software must first arm the register by writing the value 0x80. It must then write the new select code within a short, fixed number of master cycles. Writing the arm value a second time does not move or cancel the deadline. A configuration input picks the select code the block takes in reset: divide-by-1 or divide-by-8.

Top module: `clkdiv_guard`

## Requirements
- R1: Register layout. Bit 7 reads the arm flag. Bits 6:4 always read as zero. Bits 3:0 read the stored select code.
- R2: The arm flag is set only by a write whose value is exactly 0x80 (bit 7 one and bits 6:0 zero). A write with bit 7 set and any other bit set leaves the flag clear.
- R3: Suppose the arm write is taken at clock edge E0. A select write is then accepted at edges E0+1 through E0+4. The flag reads zero after edge E0+4, so a select write at E0+5 is rejected.
- R4: Writing 0x80 again while the flag is set has no effect. The flag stays set and the deadline stays at E0+4.
- R5: A write with bit 7 zero while the flag is set loads bits 3:0 into the select and clears the flag. Bits 6:4 of that write are dropped. Every other write leaves the select unchanged.
- R6: For select codes 0 to 8, `tick` is a single-cycle pulse that repeats every 2^code master cycles (1, 2, 4, ... 256). At code 0, `tick` stays high.
- R7: Select codes 9 to 15 are stored and read back unchanged. They divide by 256.
- R8: While `rst` is high, the flag clears and the select loads 3 (divide-by-8) if `boot_div8` is 1, or 0 (divide-by-1) if it is 0.
- R9: A new select takes effect at the next terminal count. The period already running completes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_div8 | input | 1 | Reset select: 1 gives code 3, 0 gives code 0 |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value {flag, 3'b000, select} |
| tick | output | 1 | Divided clock-enable pulse |

## Verification
The register state is visible on `rd_data` one edge after the write that changes it. The bench drives each write just after a rising edge and queues the expected register value. It then compares that value at the next falling edge, which is half a cycle after the capturing edge.

The window tests count edges exactly. A select write placed three idle cycles after the arm write lands on the fourth edge and must be taken. A write placed four idle cycles after lands on the fifth edge and must be refused.

Each `tick` is timestamped with a bench cycle counter. After a select change, the bench skips two pulses before comparing the spacing, so the period still running at the old length is not counted. The carry-over check (R9) instead measures that first gap on purpose and expects the old length.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int SEL_W    = 4;
  localparam int RSV_W    = FLAG_BIT - SEL_W;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SEL_BOOT_FAST = sel_t'(0);
  localparam sel_t SEL_BOOT_SLOW = sel_t'(3);
endpackage

// File: rtl/clkdiv_unlock.sv
module clkdiv_unlock #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_req,
  input  logic sel_take,
  output logic armed
);
  localparam int CNT_W = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] age;

  // A repeated arm request while armed is ignored: no restart, no clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      age   <= '0;
    end else if (armed) begin
      if (sel_take || age == LAST) begin
        armed <= 1'b0;
        age   <= '0;
      end else begin
        age <= age + 1'b1;
      end
    end else if (arm_req) begin
      armed <= 1'b1;
      age   <= '0;
    end
  end
endmodule

// File: rtl/clkdiv_sel_reg.sv
module clkdiv_sel_reg
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic boot_div8,
  input  logic load,
  input  sel_t din,
  output sel_t sel
);
  always_ff @(posedge clk) begin
    if (rst)       sel <= boot_div8 ? SEL_BOOT_SLOW : SEL_BOOT_FAST;
    else if (load) sel <= din;
  end
endmodule

// File: rtl/clkdiv_pulse.sv
module clkdiv_pulse #(
  parameter int SEL_W   = 4,
  parameter int MAX_LOG = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CODES = 1 << SEL_W;
  localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

  logic [CNT_W-1:0] term_tab [CODES];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term_q;

  // Codes above MAX_LOG saturate at the longest period.
  for (genvar c = 0; c < CODES; c++) begin : g_term
    localparam int LG = (c > MAX_LOG) ? MAX_LOG : c;
    assign term_tab[c] = CNT_W'((64'd1 << LG) - 64'd1);
  end

  // The terminal value is reloaded only at the end of a period.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      term_q <= term_tab[sel];
      tick   <= 1'b0;
    end else if (cnt >= term_q) begin
      cnt    <= '0;
      term_q <= term_tab[sel];
      tick   <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/clkdiv_guard.sv
module clkdiv_guard
  import clkdiv_pkg::*;
#(
  parameter int WIN_CYC = 4,
  parameter int MAX_LOG = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_div8,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick
);
  logic armed;
  logic arm_req;
  logic sel_take;
  sel_t sel;

  assign arm_req  = wr_en && wr_data[FLAG_BIT] && (wr_data[FLAG_BIT-1:0] == '0);
  assign sel_take = wr_en && !wr_data[FLAG_BIT] && armed;

  clkdiv_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk      (clk),
    .rst      (rst),
    .arm_req  (arm_req),
    .sel_take (sel_take),
    .armed    (armed)
  );

  clkdiv_sel_reg u_sel (
    .clk       (clk),
    .rst       (rst),
    .boot_div8 (boot_div8),
    .load      (sel_take),
    .din       (wr_data[SEL_W-1:0]),
    .sel       (sel)
  );

  clkdiv_pulse #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel),
    .tick (tick)
  );

  assign rd_data = {armed, {RSV_W{1'b0}}, sel};
endmodule

// File: rtl/clkdiv_guard_chk.sv
module clkdiv_guard_chk
  import clkdiv_pkg::*;
#(
  parameter int WIN_CYC = 4,
  parameter int MAX_LOG = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             boot_div8,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             tick
);
  localparam int RUN_W = $clog2(WIN_CYC + 2) + 1;
  localparam int GAP_W = MAX_LOG + 2;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'((1 << MAX_LOG) - 1);

  logic [RUN_W-1:0] flag_run;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_run <= '0;
      gap      <= '0;
    end else begin
      if (!rd_data[FLAG_BIT])             flag_run <= '0;
      else if (flag_run <= RUN_W'(WIN_CYC)) flag_run <= flag_run + 1'b1;
      if (tick)                gap <= '0;
      else if (gap <= GAP_MAX) gap <= gap + 1'b1;
    end
  end

  p_resv_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rd_data[FLAG_BIT-1:SEL_W] == '0);

  p_bad_arm_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[FLAG_BIT] && (wr_data[FLAG_BIT-1:0] != '0) && !rd_data[FLAG_BIT])
    |=> !rd_data[FLAG_BIT]);

  p_window_len_r3: assert property (@(posedge clk) disable iff (rst)
    flag_run <= RUN_W'(WIN_CYC));

  p_sel_load_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[FLAG_BIT] && rd_data[FLAG_BIT])
    |=> (rd_data[SEL_W-1:0] == $past(wr_data[SEL_W-1:0])) && !rd_data[FLAG_BIT]);

  p_sel_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !wr_data[FLAG_BIT] && rd_data[FLAG_BIT]) |=> $stable(rd_data[SEL_W-1:0]));

  p_gap_max_r7: assert property (@(posedge clk) disable iff (rst)
    gap <= GAP_MAX);
endmodule

bind clkdiv_guard clkdiv_guard_chk #(.WIN_CYC(WIN_CYC), .MAX_LOG(MAX_LOG)) chk_i (.*);

// File: tb/clkdiv_guard_tb_top.sv
module clkdiv_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       boot_div8 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_tick_cyc = 0;
  int last_gap = 0;
  int tick_seen = 0;
  logic [7:0] cur = 8'h00;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  clkdiv_guard dut_i (
    .clk(clk), .rst(rst), .boot_div8(boot_div8), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Register monitor: one expected value per falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(rd_data == it.exp, it.tag, int'(rd_data), int'(it.exp));
    end
  end

  // Tick monitor: gap between consecutive pulses.
  always @(negedge clk) begin
    if (!rst && tick) begin
      last_gap      = cyc - last_tick_cyc;
      last_tick_cyc = cyc;
      tick_seen++;
    end
  end

  task automatic expect_rd(input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic wait_ticks(input int k);
    int s;
    s = tick_seen;
    while (tick_seen < s + k) @(negedge clk);
  endtask

  task automatic set_div(input logic [7:0] v, input string tag);
    wr(8'h80); expect_rd({1'b1, 3'b000, cur[3:0]}, "R2");
    wr(v);     cur = {4'h0, v[3:0]}; expect_rd(cur, tag);
  endtask

  task automatic gap_check(input int n, input string tag);
    wait_ticks(3);
    chk(last_gap == n, tag, last_gap, n);
  endtask

  task automatic do_reset(input logic b8);
    drain();
    boot_div8 = b8;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    // R8: reset to divide-by-1
    do_reset(1'b0);
    cur = 8'h00;
    expect_rd(8'h00, "R8");
    idle(1);
    gap_check(1, "R8 R6 code0");

    // R3: accepted on the fourth edge after arming
    wr(8'h80); expect_rd(8'h80, "R3");
    idle(3);
    wr(8'h02); cur = 8'h02; expect_rd(8'h02, "R3 edge4 accept");
    gap_check(4, "R3 R6 code2");

    // R3: one cycle too late
    wr(8'h80); expect_rd(8'h82, "R3");
    idle(4); expect_rd(8'h02, "R3 flag clears");
    wr(8'h05); expect_rd(8'h02, "R3 late write ignored");

    // R4: repeated arm neither clears nor extends
    wr(8'h80); expect_rd(8'h82, "R4");
    wr(8'h80); expect_rd(8'h82, "R4 flag kept");
    idle(3); expect_rd(8'h02, "R4 no extension");
    wr(8'h06); expect_rd(8'h02, "R4 edge5 rejected");

    // R2: arm with other bits set is not accepted
    wr(8'h81); expect_rd(8'h02, "R2 bad arm");
    wr(8'h07); expect_rd(8'h02, "R2 R5 select held");
    wr(8'h07); expect_rd(8'h02, "R5 plain write ignored");

    // R1/R5: reserved bits dropped on select write
    wr(8'h80); expect_rd(8'h82, "R1");
    wr(8'h75); cur = 8'h05; expect_rd(8'h05, "R1 R5 reserved zero");
    gap_check(32, "R6 code5");

    // R6/R7: spacing for every code
    for (int c = 0; c < 16; c++) begin
      int n;
      n = 1 << ((c > 8) ? 8 : c);
      set_div(8'(c), (c > 8) ? "R7 readback" : "R5 readback");
      gap_check(n, (c > 8) ? "R7 reserved spacing" : "R6 spacing");
    end

    // R8: reset to divide-by-8
    do_reset(1'b1);
    cur = 8'h03;
    expect_rd(8'h03, "R8 boot div8");
    idle(1);
    gap_check(8, "R8 div8 spacing");

    // R9: running period completes at old length
    drain();
    wait_ticks(1);
    wr(8'h80);
    wr(8'h01); cur = 8'h01; expect_rd(8'h01, "R9");
    wait_ticks(1);
    chk(last_gap == 8, "R9 old period", last_gap, 8);
    wait_ticks(1);
    chk(last_gap == 2, "R9 new period", last_gap, 2);

    drain();
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule